// File: doc/BRIEF.md
# Pilot Least-Squares Channel Estimator

This block sits after the FFT of an OFDM receiver and produces a channel estimate for each loaded subcarrier. Frequency-domain samples arrive one subcarrier per valid cycle. Each sample carries its FFT bin number and its symbol index within a 12-symbol frame. In the pilot-bearing symbols, the block takes the sample at each pilot bin and divides it by the known pilot value. It does this by multiplying by the conjugate of the pilot. The resulting least-squares estimate is kept in a small buffer, one entry per pilot.

In every other symbol of the frame, each loaded subcarrier that comes in produces an output one cycle later: a channel value for that bin. The value comes from a straight-line interpolation between the two stored pilot estimates that bracket the bin. A set of estimates stays in use until the next pilot symbol replaces it. The bins below and above the loaded band are guard carriers, and the block ignores them.

The band starts at bin GUARD. Pilots sit every SPACING bins from that bin upwards. The loaded band ends on the last pilot that still fits below the upper guard, so pilots sit on both edges of the band. With the default parameters the band covers bins 208 to 814, with 102 pilots.

Top module: `pilot_ls_chest`

## Requirements
- R1: After reset, out_valid is 0 and every stored estimate is zero. A data-symbol bin that arrives before any pilot symbol therefore yields out_re = out_im = 0.
- R2: Bins below 208 or above 814 never produce an output and never change a stored estimate.
- R3: Symbols 0, 4 and 8 are pilot symbols. Their samples produce no output. Any symbol index of 12 or more produces no output either.
- R4: The pilot with index k sits at bin 208+6k, for k from 0 to 101. Its transmitted value is (sr + j·si)/√2, where sr = −1 if bit 0 of k is set (otherwise +1) and si = −1 if bit 1 of k is set (otherwise +1). The stored estimate is re = floor((yr·sr + yi·si)/2) and im = floor((yi·sr − yr·si)/2). Estimates are W+1 bits wide, so a full-scale input does not wrap.
- R5: In a data symbol, take a bin at offset o = bin−208 and let k = o/6 and j = o mod 6. For j = 0 the output is the stored estimate k. Otherwise the output is (H[k]·(6−j) + H[k+1]·j)/6, computed separately for re and im and truncated toward zero.
- R6: Stored estimates change only at pilot bins of pilot symbols. Data symbols and non-pilot bins of a pilot symbol leave them unchanged.
- R7: The output for an input sample appears on the clock edge after the one that captures it. out_bin repeats that sample's bin, and out_valid is 0 in any cycle that does not follow a qualifying input.
- R8: The top pilot, at offset 606, is returned exactly. Offset 605 is interpolated between pilots 100 and 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sym | input | 4 | Symbol index within the frame |
| in_bin | input | 10 | FFT bin of the sample |
| in_re | input | 12 | Received real part, signed |
| in_im | input | 12 | Received imaginary part, signed |
| out_valid | output | 1 | Estimate strobe |
| out_bin | output | 10 | Bin the estimate belongs to |
| out_re | output | 13 | Channel estimate real part, signed |
| out_im | output | 13 | Channel estimate imaginary part, signed |

## Verification
The interpolated estimate for a data-symbol bin is due one rising edge after the edge that captures the input. A pilot write is visible to any read issued in the next cycle. The bench drives each sample on a falling edge and lowers in_valid on the next falling edge. It samples out_valid, out_bin and the estimate at that moment, which is half a period after the capturing edge. Checks that something is absent (guard bins, pilot symbols, out-of-frame symbols, the idle cycle after a result) are sampled at that same point.

// File: rtl/pilot_ls_chest.sv
module pilot_ls_chest #(
  parameter int NFFT    = 1024,
  parameter int GUARD   = 208,
  parameter int SPACING = 6,
  parameter int NSYM    = 12,
  parameter int PSTEP   = 4,
  parameter int W       = 12,
  localparam int BW     = $clog2(NFFT),
  localparam int SW     = $clog2(NSYM),
  localparam int EW     = W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SW-1:0]        in_sym,
  input  logic [BW-1:0]        in_bin,
  input  logic signed [W-1:0]  in_re,
  input  logic signed [W-1:0]  in_im,
  output logic                 out_valid,
  output logic [BW-1:0]        out_bin,
  output logic signed [EW-1:0] out_re,
  output logic signed [EW-1:0] out_im
);
  localparam int NP   = (NFFT - 2*GUARD - 1) / SPACING + 1;
  localparam int LAST = GUARD + (NP - 1) * SPACING;
  localparam int KW   = $clog2(NP);
  localparam int JW   = $clog2(SPACING);
  localparam int NW   = EW + JW + 2;
  localparam logic signed [NW-1:0] SPC = NW'(SPACING);

  logic signed [EW-1:0] h_re [NP];
  logic signed [EW-1:0] h_im [NP];

  logic in_band, pilot_sym, data_sym, wr_en;
  logic [BW-1:0] off;
  logic [KW-1:0] k, kr, kp;
  logic [JW-1:0] jj;

  assign in_band   = (in_bin >= BW'(GUARD)) && (in_bin <= BW'(LAST));
  assign pilot_sym = (32'(in_sym) < NSYM) && ((32'(in_sym) % PSTEP) == 0);
  assign data_sym  = (32'(in_sym) < NSYM) && !pilot_sym;
  assign off       = in_bin - BW'(GUARD);
  assign k         = KW'(32'(off) / SPACING);
  assign jj        = JW'(32'(off) % SPACING);
  assign kr        = in_band ? k : '0;
  assign kp        = (32'(kr) == NP - 1) ? kr : kr + 1'b1;
  assign wr_en     = in_valid && pilot_sym && in_band && (jj == '0);

  // least-squares estimate: y times conj of pilot, halved
  logic signed [EW-1:0] yr, yi, nyr, nyi, a_re, b_re, a_im, b_im;
  logic signed [EW:0]   s_re, s_im;
  assign yr   = EW'(in_re);
  assign yi   = EW'(in_im);
  assign nyr  = -yr;
  assign nyi  = -yi;
  assign a_re = kr[0] ? nyr : yr;
  assign b_re = kr[1] ? nyi : yi;
  assign a_im = kr[0] ? nyi : yi;
  assign b_im = kr[1] ? nyr : yr;
  assign s_re = (EW+1)'(a_re) + (EW+1)'(b_re);
  assign s_im = (EW+1)'(a_im) - (EW+1)'(b_im);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        h_re[i] <= '0;
        h_im[i] <= '0;
      end
    end else if (wr_en) begin
      h_re[kr] <= s_re[EW:1];
      h_im[kr] <= s_im[EW:1];
    end
  end

  // first-order interpolation between bracketing pilots
  logic signed [NW-1:0] wlo, whi, n_re, n_im, q_re, q_im;
  assign whi  = NW'(jj);
  assign wlo  = SPC - whi;
  assign n_re = NW'(h_re[kr]) * wlo + NW'(h_re[kp]) * whi;
  assign n_im = NW'(h_im[kr]) * wlo + NW'(h_im[kp]) * whi;
  assign q_re = n_re / SPC;
  assign q_im = n_im / SPC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bin   <= '0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid && data_sym && in_band;
      out_bin   <= in_bin;
      out_re    <= EW'(q_re);
      out_im    <= EW'(q_im);
    end
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R3
  pilot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pilot_sym) |=> !out_valid);
  // R2
  guard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_band) |=> !out_valid);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && pilot_sym) |=> ($stable(h_re[0]) && $stable(h_im[0])));
  // R8
  top_pilot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && pilot_sym && in_bin == BW'(LAST)) |=> ($stable(h_re[NP-1]) && $stable(h_im[NP-1])));
endmodule

// File: tb/pilot_ls_chest_tb.sv
module pilot_ls_chest_tb_top;
  localparam int CLK_P = 10;
  localparam int GUARD = 208;
  localparam int NP    = 102;
  localparam int NPROBE = 10;
  localparam int PROBE [NPROBE] = '{0, 1, 2, 3, 5, 6, 7, 300, 605, 606};

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [3:0] in_sym = 0;
  logic [9:0] in_bin = 0;
  logic signed [11:0] in_re = 0, in_im = 0;
  logic out_valid;
  logic [9:0] out_bin;
  logic signed [12:0] out_re, out_im;

  int tests = 0, fails = 0;
  bit done = 0;
  int he_re [NP];
  int he_im [NP];

  always #(CLK_P/2) clk = ~clk;

  pilot_ls_chest dut_i (.clk, .rst_n, .in_valid, .in_sym, .in_bin, .in_re, .in_im,
                        .out_valid, .out_bin, .out_re, .out_im);

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int sym, int bin, int re, int im);
    @(negedge clk);
    in_valid = 1; in_sym = 4'(sym); in_bin = 10'(bin);
    in_re = 12'(re); in_im = 12'(im);
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic int pv_re(int k, int seed);
    if (seed == 2 && k == 3) return -2048;
    if (seed == 2 && k == 4) return 2047;
    return ((k*37 + seed*11) % 401) - 200;
  endfunction
  function automatic int pv_im(int k, int seed);
    if (seed == 2 && k == 3) return -2048;
    if (seed == 2 && k == 4) return 2047;
    return ((k*53 + seed*3) % 401) - 200;
  endfunction

  task automatic pilot_symbol(int sym, int seed, output int any_out);
    any_out = 0;
    for (int k = 0; k < NP; k++) begin
      int yr = pv_re(k, seed), yi = pv_im(k, seed);
      int sr = k[0] ? -1 : 1, si = k[1] ? -1 : 1;
      drive(sym, GUARD + 6*k, yr, yi);
      any_out |= int'(out_valid);
      he_re[k] = (yr*sr + yi*si) >>> 1;
      he_im[k] = (yi*sr - yr*si) >>> 1;
    end
  endtask

  task automatic probe(string req, int sym, int o);
    int k = o / 6, j = o % 6, er, ei;
    if (j == 0) begin er = he_re[k]; ei = he_im[k]; end
    else begin
      er = (he_re[k]*(6-j) + he_re[k+1]*j) / 6;
      ei = (he_im[k]*(6-j) + he_im[k+1]*j) / 6;
    end
    drive(sym, GUARD + o, 0, 0);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " bin"}, int'(out_bin), GUARD + o);
    check({req, " re"}, int'(out_re), er);
    check({req, " im"}, int'(out_im), ei);
  endtask

  initial begin
    int any;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    rst_n = 1;
    for (int k = 0; k < NP; k++) begin he_re[k] = 0; he_im[k] = 0; end
    probe("R1 zero before pilots", 1, 300);

    pilot_symbol(0, 1, any);
    check("R3 no output in pilot symbol", any, 0);
    drive(0, GUARD + 7, 900, -900);
    check("R3 pilot symbol data bin", int'(out_valid), 0);
    drive(0, 100, 1500, 1500);
    check("R2 guard bin in pilot symbol", int'(out_valid), 0);

    for (int p = 0; p < NPROBE; p++) probe("R5 interp sym1", 1, PROBE[p]);
    probe("R8 top pilot", 2, 606);
    probe("R8 below top pilot", 2, 605);
    @(negedge clk);
    check("R7 idle after result", int'(out_valid), 0);
    drive(1, 207, 0, 0);
    check("R2 lower guard", int'(out_valid), 0);
    drive(1, 815, 0, 0);
    check("R2 upper guard", int'(out_valid), 0);
    drive(1, 1023, 0, 0);
    check("R2 top bin", int'(out_valid), 0);
    drive(12, GUARD + 6, 0, 0);
    check("R3 symbol beyond frame", int'(out_valid), 0);
    probe("R6 held through sym3", 3, 301);

    pilot_symbol(4, 2, any);
    check("R3 no output in pilot symbol 4", any, 0);
    drive(4, GUARD + 13, -2000, 2000);
    for (int p = 0; p < NPROBE; p++) probe("R5 interp sym5", 5, PROBE[p]);
    probe("R4 full-scale pilot", 6, 18);
    probe("R4 positive full scale", 6, 24);
    probe("R6 non-pilot bin left intact", 7, 13);

    pilot_symbol(8, 3, any);
    check("R3 no output in pilot symbol 8", any, 0);
    probe("R5 interp sym9", 9, 1);
    probe("R5 interp sym11", 11, 604);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule